// File: doc/BRIEF.md
# Descriptor Ring Sequencer

This block walks a circular ring of 16-byte work descriptors held in system memory. Each entry names a 48-bit source, a 48-bit destination and a byte count, and carries an ownership flag. While the flag is set the entry belongs to the hardware. The sequencer reads an entry one 32-bit word at a time and hands the transfer to a separate copy datapath. When the copy is acknowledged it rewrites the entry's first word with the ownership flag cleared, a completion status and the count of bytes left unmoved. It then steps to the next slot, returning to slot zero after the last programmed slot.

Software hands work over by filling entries and setting their ownership flags, then pulses start. No producer index exists. The engine runs until it reads an entry whose ownership flag is clear, then parks on that slot and raises a sticky stop flag. Software then releases more entries and pulses start again to resume from that slot. A pause command lets the entry in flight finish and halts at the next entry boundary.

Top module: `desc_ring_engine`

## Requirements
- R1: After reset the engine is idle: no memory or copy request is raised, the ring index is 0 and every flag and event output is low.
- R2: An entry is fetched as four word reads at ring_base + 16*index + 0, 4, 8, 12. In word 0, bit 31 is the ownership flag, bit 30 requests a completion event and bits 26:0 are the byte count. In word 1, bits 15:0 are destination bits 47:32 and bits 31:16 are source bits 47:32. Word 2 holds destination bits 31:0 and word 3 holds source bits 31:0. Entries are handled strictly in ring order, and the write-back of one entry completes before the next entry is read.
- R3: An entry whose word 0 bit 31 is 0 stops the engine on that slot, with the index unchanged and no copy issued. The stop flag is then set until the next accepted start, which clears it.
- R4: One copy request is issued per non-empty entry. It carries the entry's full 48-bit addresses and its length, is held steady until acknowledged, and never overlaps a memory request.
- R5: When write-back was enabled at the accepted start, word 0 is rewritten as follows. Bit 31 is 0. Bit 30 marks success, bit 29 a read failure and bit 28 a write failure; a read failure takes precedence when both are reported. Bit 27 is 0, and bits 26:0 hold the byte count minus the bytes moved. When write-back is disabled, memory is left untouched.
- R6: An entry with a byte count of 0 issues no copy request. It completes as a success with a residual of 0.
- R7: A copy acknowledged with a read or write failure produces a one-cycle error event, and the engine continues with the next entry.
- R8: A one-cycle completion event is produced for each finished entry whose word 0 bit 30 was set.
- R9: The index advances by one per finished entry and returns to 0 after ring_count - 1.
- R10: A pause while busy lets the current entry finish, then idles at the next boundary with a one-cycle pause-done pulse. A pause while idle gives the pulse on the next cycle. A later start resumes at the following slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start/resume pulse, taken when idle |
| pause_i | input | 1 | Stop-at-boundary pulse |
| wb_en_i | input | 1 | Write-back enable, sampled on start |
| ring_base_i | input | 48 | Byte address of ring slot 0 |
| ring_count_i | input | IDX_W | Number of ring slots |
| mem_req_o | output | 1 | Memory word request, held until acknowledged |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 48 | Word byte address |
| mem_wdata_o | output | 32 | Write data (write-back word) |
| mem_ack_i | input | 1 | Memory acknowledge, read data valid |
| mem_rdata_i | input | 32 | Read data |
| cp_req_o | output | 1 | Copy request, held until acknowledged |
| cp_src_o | output | 48 | Copy source address |
| cp_dst_o | output | 48 | Copy destination address |
| cp_len_o | output | 27 | Copy byte count |
| cp_ack_i | input | 1 | Copy finished |
| cp_rd_err_i | input | 1 | Copy hit a read failure |
| cp_wr_err_i | input | 1 | Copy hit a write failure |
| cp_moved_i | input | 27 | Bytes actually moved |
| busy_o | output | 1 | Engine is walking the ring |
| ring_idx_o | output | IDX_W | Current ring slot |
| inval_stop_o | output | 1 | Sticky: stopped on a non-owned entry |
| pause_done_o | output | 1 | Pause reached pulse |
| desc_done_o | output | 1 | Completion event pulse |
| copy_err_o | output | 1 | Copy failure event pulse |

## Verification
The ring is programmed with four slots, and eight successive batches of one to three entries are released. The batches sweep byte counts of zero, one, a mid value, 64 and the 27-bit maximum, across all four copy outcomes and both settings of the event flag. Each batch parks at a new slot, so wrap-around, the precedence of read failure over write failure, and the skip of empty entries are each seen in isolation. A second pattern disables write-back so that every slot stays owned and the engine laps the ring until a pause arrives. This separates pause-at-boundary from stop-on-invalid and shows that memory is left unchanged. Clearing all ownership flags and restarting then shows a stop with no copy, and a pause while idle checks the immediate pulse.

// File: rtl/dre_pkg.sv
package dre_pkg;
  localparam int LEN_W  = 27;
  localparam int ADDR_W = 48;
  localparam int WORD_W = 32;
  localparam int HALF_W = 16;

  localparam int OWN_BIT  = 31;
  localparam int IRQ_BIT  = 30;
  localparam int OK_BIT   = 30;
  localparam int RDF_BIT  = 29;
  localparam int WRF_BIT  = 28;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD0, ST_RD1, ST_RD2, ST_RD3, ST_COPY, ST_WB, ST_DONE
  } dre_state_e;

  typedef struct packed {
    logic              irq;
    logic [LEN_W-1:0]  len;
    logic [ADDR_W-1:0] dst;
    logic [ADDR_W-1:0] src;
  } dre_desc_t;

  typedef struct packed {
    logic             rd_fail;
    logic             wr_fail;
    logic [LEN_W-1:0] moved;
  } dre_result_t;
endpackage

// File: rtl/dre_ring_ptr.sv
module dre_ring_ptr #(
  parameter int IDX_W  = 12,
  parameter int ADDR_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_i,
  input  logic [IDX_W-1:0]  count_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [1:0]        word_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int SLOT_SH = 4;

  logic [IDX_W-1:0] idx_q, idx_n;
  logic [IDX_W-1:0] last_idx;

  assign last_idx = count_i - IDX_W'(1);

  always_comb begin
    if (idx_q >= last_idx) idx_n = '0;
    else                   idx_n = idx_q + IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     idx_q <= '0;
    else if (adv_i) idx_q <= idx_n;
  end

  assign idx_o  = idx_q;
  assign addr_o = base_i + ADDR_W'({idx_q, {SLOT_SH{1'b0}}}) + ADDR_W'({word_i, 2'b00});
endmodule

// File: rtl/dre_desc_regs.sv
module dre_desc_regs
  import dre_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [1:0]        sel_i,
  input  logic [WORD_W-1:0] word_i,
  output dre_desc_t         desc_o
);
  dre_desc_t desc_q, desc_n;

  always_comb begin
    desc_n = desc_q;
    unique case (sel_i)
      2'd0: begin
        desc_n.irq = word_i[IRQ_BIT];
        desc_n.len = word_i[LEN_W-1:0];
      end
      2'd1: begin
        desc_n.dst[ADDR_W-1:WORD_W] = word_i[HALF_W-1:0];
        desc_n.src[ADDR_W-1:WORD_W] = word_i[WORD_W-1:HALF_W];
      end
      2'd2: desc_n.dst[WORD_W-1:0] = word_i;
      default: desc_n.src[WORD_W-1:0] = word_i;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      desc_q <= '0;
    else if (load_i) desc_q <= desc_n;
  end

  assign desc_o = desc_q;
endmodule

// File: rtl/dre_status_fmt.sv
module dre_status_fmt
  import dre_pkg::*;
(
  input  logic [LEN_W-1:0]  len_i,
  input  dre_result_t       res_i,
  output logic [WORD_W-1:0] word_o,
  output logic              fail_o
);
  logic [LEN_W-1:0] residual;

  always_comb begin
    if (res_i.moved >= len_i) residual = '0;
    else                      residual = len_i - res_i.moved;
    fail_o = res_i.rd_fail | res_i.wr_fail;
    word_o = '0;
    word_o[LEN_W-1:0] = residual;
    word_o[OK_BIT]    = ~fail_o;
    word_o[RDF_BIT]   = res_i.rd_fail;
    word_o[WRF_BIT]   = res_i.wr_fail & ~res_i.rd_fail;
  end
endmodule

// File: rtl/desc_ring_engine.sv
module desc_ring_engine
  import dre_pkg::*;
#(
  parameter int IDX_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              pause_i,
  input  logic              wb_en_i,
  input  logic [47:0]       ring_base_i,
  input  logic [IDX_W-1:0]  ring_count_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [47:0]       mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              cp_req_o,
  output logic [47:0]       cp_src_o,
  output logic [47:0]       cp_dst_o,
  output logic [26:0]       cp_len_o,
  input  logic              cp_ack_i,
  input  logic              cp_rd_err_i,
  input  logic              cp_wr_err_i,
  input  logic [26:0]       cp_moved_i,
  output logic              busy_o,
  output logic [IDX_W-1:0]  ring_idx_o,
  output logic              inval_stop_o,
  output logic              pause_done_o,
  output logic              desc_done_o,
  output logic              copy_err_o
);
  dre_state_e  state_q, state_n;
  dre_desc_t   desc;
  dre_result_t res_q, res_n;
  logic        wb_q, pause_q, inval_q;
  logic        done_q, err_q, pdone_q;

  logic        adv, load, res_en, start_acc;
  logic        inval_set, done_set, err_set, pdone_set, pause_clr;
  logic [1:0]  wsel;
  logic        fail;
  logic [WORD_W-1:0] wb_word;

  dre_ring_ptr #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .adv_i(adv), .count_i(ring_count_i),
    .base_i(ring_base_i), .word_i(wsel), .idx_o(ring_idx_o), .addr_o(mem_addr_o)
  );

  dre_desc_regs u_desc (
    .clk(clk), .rst_n(rst_n), .load_i(load), .sel_i(wsel),
    .word_i(mem_rdata_i), .desc_o(desc)
  );

  dre_status_fmt u_fmt (
    .len_i(desc.len), .res_i(res_q), .word_o(wb_word), .fail_o(fail)
  );

  // next-state and control decode
  always_comb begin
    state_n   = state_q;
    res_n     = res_q;
    adv       = 1'b0;
    load      = 1'b0;
    res_en    = 1'b0;
    wsel      = 2'd0;
    mem_req_o = 1'b0;
    mem_we_o  = 1'b0;
    cp_req_o  = 1'b0;
    start_acc = 1'b0;
    inval_set = 1'b0;
    done_set  = 1'b0;
    err_set   = 1'b0;
    pdone_set = 1'b0;
    pause_clr = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          start_acc = 1'b1;
          state_n   = ST_RD0;
        end else if (pause_i) begin
          pdone_set = 1'b1;
        end
      end
      ST_RD0: begin
        mem_req_o = 1'b1;
        if (mem_ack_i) begin
          if (mem_rdata_i[OWN_BIT]) begin
            load    = 1'b1;
            state_n = ST_RD1;
          end else begin
            inval_set = 1'b1;
            pause_clr = 1'b1;
            state_n   = ST_IDLE;
          end
        end
      end
      ST_RD1: begin
        wsel      = 2'd1;
        mem_req_o = 1'b1;
        if (mem_ack_i) begin
          load    = 1'b1;
          state_n = ST_RD2;
        end
      end
      ST_RD2: begin
        wsel      = 2'd2;
        mem_req_o = 1'b1;
        if (mem_ack_i) begin
          load    = 1'b1;
          state_n = ST_RD3;
        end
      end
      ST_RD3: begin
        wsel      = 2'd3;
        mem_req_o = 1'b1;
        if (mem_ack_i) begin
          load   = 1'b1;
          res_en = 1'b1;
          res_n  = '0;
          if (desc.len == '0) state_n = wb_q ? ST_WB : ST_DONE;
          else                state_n = ST_COPY;
        end
      end
      ST_COPY: begin
        cp_req_o = 1'b1;
        if (cp_ack_i) begin
          res_en        = 1'b1;
          res_n.rd_fail = cp_rd_err_i;
          res_n.wr_fail = cp_wr_err_i;
          res_n.moved   = cp_moved_i;
          state_n       = wb_q ? ST_WB : ST_DONE;
        end
      end
      ST_WB: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
        if (mem_ack_i) state_n = ST_DONE;
      end
      default: begin
        adv      = 1'b1;
        done_set = desc.irq;
        err_set  = fail;
        if (pause_q || pause_i) begin
          pdone_set = 1'b1;
          pause_clr = 1'b1;
          state_n   = ST_IDLE;
        end else begin
          state_n = ST_RD0;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_q <= '0;
    else if (res_en) res_q <= res_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         wb_q <= 1'b0;
    else if (start_acc) wb_q <= wb_en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             pause_q <= 1'b0;
    else if (pause_clr || start_acc)        pause_q <= 1'b0;
    else if (pause_i && state_q != ST_IDLE) pause_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         inval_q <= 1'b0;
    else if (start_acc) inval_q <= 1'b0;
    else if (inval_set) inval_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      pdone_q <= 1'b0;
    end else begin
      done_q  <= done_set;
      err_q   <= err_set;
      pdone_q <= pdone_set;
    end
  end

  assign mem_wdata_o  = wb_word;
  assign cp_src_o     = desc.src;
  assign cp_dst_o     = desc.dst;
  assign cp_len_o     = desc.len;
  assign busy_o       = (state_q != ST_IDLE);
  assign inval_stop_o = inval_q;
  assign pause_done_o = pdone_q;
  assign desc_done_o  = done_q;
  assign copy_err_o   = err_q;
endmodule

// File: rtl/dre_checker.sv
module dre_checker #(
  parameter int IDX_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IDX_W-1:0] ring_count_i,
  input logic             mem_req_o,
  input logic             mem_we_o,
  input logic [47:0]      mem_addr_o,
  input logic [31:0]      mem_wdata_o,
  input logic             mem_ack_i,
  input logic [31:0]      mem_rdata_i,
  input logic             cp_req_o,
  input logic [47:0]      cp_src_o,
  input logic [26:0]      cp_len_o,
  input logic             cp_ack_i,
  input logic             busy_o,
  input logic [IDX_W-1:0] ring_idx_o,
  input logic             inval_stop_o,
  input logic             desc_done_o
);
  // R4: copy and memory traffic never overlap
  a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req_o && cp_req_o));

  // R4: copy request held steady until acknowledged
  a_r4_copy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cp_req_o && !cp_ack_i |=> cp_req_o && $stable(cp_src_o) && $stable(cp_len_o));

  // R2: memory request held steady until acknowledged
  a_r2_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  // R5: write-back always returns ownership to software
  a_r5_wb_clears_own: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && mem_we_o |-> !mem_wdata_o[31]);

  // R3: the stop flag only follows a read of a non-owned word
  a_r3_stop_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inval_stop_o) |-> $past(mem_ack_i && !mem_we_o && !mem_rdata_i[31]));

  // R9: index stays inside the programmed ring while running
  a_r9_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && ring_count_i != '0 |-> ring_idx_o < ring_count_i);

  // R8: completion event lasts one cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    desc_done_o |=> !desc_done_o);

  // R6: an empty entry never reaches the copy datapath
  a_r6_no_empty_copy: assert property (@(posedge clk) disable iff (!rst_n)
    cp_req_o |-> cp_len_o != '0);
endmodule

bind desc_ring_engine dre_checker #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ring_count_i(ring_count_i),
  .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
  .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
  .cp_req_o(cp_req_o), .cp_src_o(cp_src_o), .cp_len_o(cp_len_o),
  .cp_ack_i(cp_ack_i), .busy_o(busy_o), .ring_idx_o(ring_idx_o),
  .inval_stop_o(inval_stop_o), .desc_done_o(desc_done_o)
);

// File: tb/desc_ring_engine_bench.sv
module desc_ring_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 12;
  localparam logic [47:0] BASE = 48'h0ABC_0000_0100;

  logic clk, rst_n, start, pause, wb_en;
  logic [IDX_W-1:0] ring_count;
  logic mem_req, mem_we, mem_ack;
  logic [47:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic cp_req, cp_ack, cp_rd_err, cp_wr_err;
  logic [47:0] cp_src, cp_dst;
  logic [26:0] cp_len, cp_moved;
  logic busy, inval_stop, pause_done, desc_done, copy_err;
  logic [IDX_W-1:0] ring_idx;

  desc_ring_engine #(.IDX_W(IDX_W)) u_desc_ring_engine (
    .clk(clk), .rst_n(rst_n), .start_i(start), .pause_i(pause), .wb_en_i(wb_en),
    .ring_base_i(BASE), .ring_count_i(ring_count),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .cp_req_o(cp_req), .cp_src_o(cp_src), .cp_dst_o(cp_dst), .cp_len_o(cp_len),
    .cp_ack_i(cp_ack), .cp_rd_err_i(cp_rd_err), .cp_wr_err_i(cp_wr_err),
    .cp_moved_i(cp_moved), .busy_o(busy), .ring_idx_o(ring_idx),
    .inval_stop_o(inval_stop), .pause_done_o(pause_done),
    .desc_done_o(desc_done), .copy_err_o(copy_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_vec = 0, n_bad = 0;
  logic [31:0] mem [0:15];
  int cp_total = 0, done_total = 0, err_total = 0, pdone_total = 0, addr_bad = 0;
  logic [47:0] log_src [0:15];
  logic [47:0] log_dst [0:15];
  logic [26:0] log_len [0:15];
  int cp_cnt = 0;

  // memory model: one-cycle acknowledge
  always @(posedge clk) begin
    if (mem_ack) mem_ack <= 1'b0;
    else if (mem_req) begin
      mem_ack <= 1'b1;
      if (mem_addr - BASE >= 48'd64) addr_bad <= addr_bad + 1;
      if (mem_we) mem[mem_addr[5:2]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[5:2]];
    end
  end

  // copy model: outcome coded in the low two source bits
  always @(posedge clk) begin
    if (cp_ack) begin
      cp_ack <= 1'b0;
      cp_cnt <= 0;
    end else if (cp_req) begin
      if (cp_cnt == 2) begin
        cp_ack    <= 1'b1;
        cp_rd_err <= cp_src[0];
        cp_wr_err <= cp_src[1];
        case (cp_src[1:0])
          2'd0: cp_moved <= cp_len;
          2'd1: cp_moved <= cp_len >> 1;
          2'd2: cp_moved <= cp_len >> 2;
          default: cp_moved <= '0;
        endcase
        log_src[cp_total % 16] <= cp_src;
        log_dst[cp_total % 16] <= cp_dst;
        log_len[cp_total % 16] <= cp_len;
        cp_total <= cp_total + 1;
      end else cp_cnt <= cp_cnt + 1;
    end
  end

  always @(posedge clk) begin
    if (desc_done)  done_total  <= done_total + 1;
    if (copy_err)   err_total   <= err_total + 1;
    if (pause_done) pdone_total <= pdone_total + 1;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [26:0] lenv(input int i);
    case (i)
      0: return 27'd0;
      1: return 27'd1;
      2: return 27'h155;
      3: return 27'h7FFFFFF;
      default: return 27'd64;
    endcase
  endfunction

  function automatic logic [31:0] exp_w0(input logic [26:0] len, input int mode);
    logic [26:0] moved;
    if (len == 0) return 32'h4000_0000;
    case (mode)
      0: moved = len;
      1: moved = len >> 1;
      2: moved = len >> 2;
      default: moved = 27'd0;
    endcase
    return {1'b0, mode == 0, mode == 1 || mode == 3, mode == 2, 1'b0, len - moved};
  endfunction

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int cur;
    rst_n = 1'b0; start = 1'b0; pause = 1'b0; wb_en = 1'b1; ring_count = 4;
    mem_ack = 1'b0; mem_rdata = '0; cp_ack = 1'b0; cp_rd_err = 1'b0;
    cp_wr_err = 1'b0; cp_moved = '0;
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(!busy && !mem_req && !cp_req, "R1 idle", {busy, mem_req, cp_req}, 0);
    check(ring_idx == 0, "R1 index", ring_idx, 0);
    check(!inval_stop && !desc_done && !copy_err && !pause_done, "R1 flags",
          {inval_stop, desc_done, copy_err, pause_done}, 0);

    cur = 0;
    for (int r = 0; r < 8; r++) begin
      int k, cp0, dn0, er0, n_cp, n_irq, n_err, nth;
      int pos_a [0:2];
      int mode_a [0:2];
      logic [26:0] len_a [0:2];
      k = r % 3 + 1;
      n_cp = 0; n_irq = 0; n_err = 0;
      for (int j = 0; j < k; j++) begin
        int pos, mode, irq;
        pos = (cur + j) % 4; mode = (r + j) % 4; irq = (r + j) % 2;
        pos_a[j] = pos; mode_a[j] = mode; len_a[j] = lenv((r * 3 + j) % 5);
        mem[pos*4+0] = {1'b1, irq[0], 3'b000, 27'(len_a[j])} ;
        mem[pos*4+1] = {16'h0200 + 16'(pos), 16'h0100 + 16'(pos)};
        mem[pos*4+2] = 32'h6000_0000 | (r << 8) | (j << 4);
        mem[pos*4+3] = 32'h5000_0000 | (r << 8) | (j << 4) | mode;
        if (len_a[j] != 0) begin
          n_cp++;
          if (mode != 0) n_err++;
        end
        if (irq != 0) n_irq++;
      end
      cp0 = cp_total; dn0 = done_total; er0 = err_total;
      pulse_start();
      check(!inval_stop && busy, "R3 flag cleared on start", inval_stop, 0);
      wait_idle();
      @(negedge clk);
      check(ring_idx == IDX_W'((cur + k) % 4), "R9 index after batch", ring_idx, (cur + k) % 4);
      check(inval_stop, "R3 stop on non-owned entry", inval_stop, 1);
      check(cp_total - cp0 == n_cp, "R6 copy count", cp_total - cp0, n_cp);
      check(done_total - dn0 == n_irq, "R8 completion events", done_total - dn0, n_irq);
      check(err_total - er0 == n_err, "R7 error events", err_total - er0, n_err);
      nth = 0;
      for (int j = 0; j < k; j++) begin
        logic [31:0] w;
        w = exp_w0(len_a[j], mode_a[j]);
        check(mem[pos_a[j]*4] == w, "R5 write-back word", mem[pos_a[j]*4], w);
        if (len_a[j] != 0) begin
          int li;
          logic [47:0] es, ed;
          li = (cp0 + nth) % 16;
          es = {16'h0200 + 16'(pos_a[j]), 32'h5000_0000 | (r << 8) | (j << 4) | mode_a[j]};
          ed = {16'h0100 + 16'(pos_a[j]), 32'h6000_0000 | (r << 8) | (j << 4)};
          check(log_src[li] == es, "R2 source field order", log_src[li], es);
          check(log_dst[li] == ed, "R2 destination field order", log_dst[li], ed);
          check(log_len[li] == len_a[j], "R4 copy length", log_len[li], len_a[j]);
          nth++;
        end
      end
      cur = (cur + k) % 4;
    end
    check(addr_bad == 0, "R2 fetch address in ring", addr_bad, 0);

    // R10 pause with write-back off: every slot stays owned
    begin
      int cp0, pd0, done_n;
      wb_en = 1'b0;
      for (int p = 0; p < 4; p++) begin
        mem[p*4+0] = {1'b1, 1'b0, 3'b000, 27'd64};
        mem[p*4+1] = 32'h0;
        mem[p*4+2] = 32'h7000_0000;
        mem[p*4+3] = 32'h8000_0000;
      end
      cp0 = cp_total; pd0 = pdone_total;
      pulse_start();
      for (int i = 0; i < 3000 && cp_total - cp0 < 5; i++) @(negedge clk);
      pause = 1'b1;
      @(negedge clk);
      pause = 1'b0;
      wait_idle();
      @(negedge clk);
      done_n = cp_total - cp0;
      check(!busy && pdone_total - pd0 == 1, "R10 pause done pulse", pdone_total - pd0, 1);
      check(done_n >= 5 && done_n <= 7, "R10 finish in-flight entry", done_n, 6);
      check(ring_idx == IDX_W'((cur + done_n) % 4), "R10 index at boundary", ring_idx, (cur + done_n) % 4);
      check(!inval_stop, "R10 pause is not an invalid stop", inval_stop, 0);
      for (int p = 0; p < 4; p++)
        check(mem[p*4] == {1'b1, 4'b0000, 27'd64}, "R5 write-back disabled", mem[p*4], {1'b1, 4'b0000, 27'd64});
      cur = (cur + done_n) % 4;
    end

    // R3 resume into a non-owned slot: stop with no copy
    begin
      int cp0;
      for (int p = 0; p < 4; p++) mem[p*4] = 32'h0;
      cp0 = cp_total;
      pulse_start();
      wait_idle();
      @(negedge clk);
      check(inval_stop, "R3 stop flag", inval_stop, 1);
      check(ring_idx == IDX_W'(cur), "R3 index held", ring_idx, cur);
      check(cp_total == cp0, "R3 no copy issued", cp_total - cp0, 0);
    end

    // R10 pause while idle
    pause = 1'b1;
    @(negedge clk);
    pause = 1'b0;
    check(pause_done, "R10 idle pause pulse", pause_done, 1);
    @(negedge clk);
    check(!pause_done, "R10 pulse one cycle", pause_done, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule